// File: doc/BRIEF.md
# Six-Bank Capture and Sequential Readout Engine

This block gathers samples from six parallel channels into six word-wide memory banks, 256 words each, while a capture phase is active. Each sample strobe writes one word per channel, and all six words go to the same bank address. When the capture phase ends, a readout phase begins. The readout enable is the inverse of the capture enable. In the readout phase the block plays back eight slots of 256 words each, one word per clock. Slots 0 to 5 come from banks 0 to 5, and slots 6 and 7 are filled with zeros.

One 11-bit readout counter drives the playback. Bits 7:0 give the word address inside a bank, and bits 10:8 select the slot. The counter saturates after slot 7, word 255. The block then raises a done flag, and the output stays quiet for the rest of the readout phase, however long that phase is. The next readout phase restarts playback at word 0 of slot 0. The whole block runs on a single fast clock, and the sample strobe is a one-cycle pulse in that clock domain.

The output stream is valid-only and has no back-pressure. The consumer must accept one word in every cycle where `rd_valid` is high, because the sequencer never stalls.

Top module: `bank_seq`

## Requirements
- R1: A synchronous active-high `rst` clears the write position, the readout counter and the done flag. While reset is held and in the cycle after it, `rd_valid` and `rd_done` are 0 and `rd_data` is 0.
- R2: A sample strobe taken while `cap_en` is 1 writes channel k (bits k*DATA_W +: DATA_W of `smp_data`) into bank k. All six banks use the same address. The address is 0 for the first strobe of each capture phase and rises by one with every accepted strobe.
- R3: After 256 strobes in one capture phase, any further strobes in that phase are ignored, and no bank word changes.
- R4: Strobes taken while `cap_en` is 0 write nothing.
- R5: The readout starts when `cap_en` is first seen at 0 after being 1. Two clock edges later the first word appears. After that, words follow in consecutive cycles. Stream word i carries bank i[10:8] at address i[7:0] for slots 0 to 5.
- R6: Stream words whose slot, i[10:8], is 6 or 7 are all zero.
- R7: Each readout phase gives exactly 2048 valid words. `rd_done` rises in the cycle of word 2047 and stays at 1, with `rd_valid` at 0, until the next readout phase begins. At that point `rd_done` clears.
- R8: `rd_data` is 0 in every cycle where `rd_valid` is 0.
- R9: If `cap_en` rises during a readout, the stream stops and `rd_valid` is 0 from the next cycle on. The next readout phase plays back from word 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock for capture and readout |
| rst | input | 1 | Synchronous active-high reset |
| cap_en | input | 1 | 1 = capture phase, 0 = readout phase |
| smp_stb | input | 1 | One-cycle sample strobe |
| smp_data | input | NUM_BANKS*DATA_W | Six channel words packed side by side, channel 0 in the low bits |
| rd_data | output | DATA_W | Readout word |
| rd_valid | output | 1 | `rd_data` carries a stream word |
| rd_done | output | 1 | All eight slots have been played back in this readout phase |

## Verification
A wrong readout counter or a wrong slot select shows up at once. The very next valid word carries the wrong bank or address, or carries zero where it should not. A counter that fails to saturate is also seen early: the first cycle after `rd_done` shows a stray valid word. A wrong write position can only be seen one phase later, when the following readout reaches the affected address. The bench therefore plays back every bank after each capture pattern and compares all 2048 words against its own model.

// File: rtl/bank_seq_pkg.sv
package bank_seq_pkg;
  localparam int WORD_ADDR_W = 8;
  localparam int SLOT_SEL_W  = 3;
  localparam int CHANNELS    = 6;

  typedef struct packed {
    logic                  vld;
    logic [SLOT_SEL_W-1:0] slot;
  } rd_tag_t;
endpackage

// File: rtl/bank_seq_capture.sv
module bank_seq_capture #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_en,
  input  logic          cap_rise,
  input  logic          smp_stb,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW:0]   wr_count
);
  logic [AW:0] count_q;
  logic [AW:0] count_eff;

  // A new capture phase starts from address zero in the very cycle it begins.
  assign count_eff = cap_rise ? '0 : count_q;
  assign wr_en     = cap_en & smp_stb & ~count_eff[AW];
  assign wr_addr   = count_eff[AW-1:0];
  assign wr_count  = count_q;

  always_ff @(posedge clk) begin
    if (rst)        count_q <= '0;
    else if (wr_en) count_q <= count_eff + 1'b1;
    else            count_q <= count_eff;
  end
endmodule

// File: rtl/bank_seq_banks.sv
module bank_seq_banks #(
  parameter int DW = 8,
  parameter int AW = 8,
  parameter int NB = 6
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [NB*DW-1:0] wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [NB*DW-1:0] rd_q
);
  localparam int DEPTH = 1 << AW;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] q;

    always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data[b*DW +: DW];
      if (rd_en) q <= mem[rd_addr];
    end

    assign rd_q[b*DW +: DW] = q;
  end
endmodule

// File: rtl/bank_seq_reader.sv
module bank_seq_reader #(
  parameter int AW = 8,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_en,
  input  logic          rd_rise,
  output logic          issue,
  output logic [AW-1:0] rd_addr,
  output logic [SW-1:0] slot,
  output logic          done
);
  localparam int CW = AW + SW;
  localparam logic [CW-1:0] LAST = '1;

  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic          done_q;

  assign issue   = run_q & ~cap_en;
  assign rd_addr = cnt_q[AW-1:0];
  assign slot    = cnt_q[CW-1:AW];
  assign done    = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (rd_rise) begin
      cnt_q  <= '0;
      run_q  <= 1'b1;
      done_q <= 1'b0;
    end else if (cap_en) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      if (cnt_q == LAST) begin
        // saturate: hold the counter and selector for the rest of the window
        run_q  <= 1'b0;
        done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bank_seq.sv
module bank_seq
  import bank_seq_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int NUM_BANKS = CHANNELS
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cap_en,
  input  logic                        smp_stb,
  input  logic [NUM_BANKS*DATA_W-1:0] smp_data,
  output logic [DATA_W-1:0]           rd_data,
  output logic                        rd_valid,
  output logic                        rd_done
);
  localparam int AW        = WORD_ADDR_W;
  localparam int SW        = SLOT_SEL_W;
  localparam int NUM_SLOTS = 1 << SW;

  logic                        cap_q;
  logic                        cap_rise;
  logic                        rd_rise;
  logic                        wr_en;
  logic [AW-1:0]               wr_addr;
  logic [AW:0]                 wr_count;
  logic                        issue;
  logic [AW-1:0]               rd_addr;
  logic [SW-1:0]               slot;
  logic [NUM_BANKS*DATA_W-1:0] bank_q;
  rd_tag_t                     tag_q;
  logic [SW-1:0]               out_slot;
  logic [DATA_W-1:0]           slot_word [NUM_SLOTS];

  always_ff @(posedge clk) begin
    if (rst) cap_q <= 1'b0;
    else     cap_q <= cap_en;
  end

  assign cap_rise = cap_en & ~cap_q;
  assign rd_rise  = ~cap_en & cap_q;

  bank_seq_capture #(.AW(AW)) u_capture (
    .clk     (clk),
    .rst     (rst),
    .cap_en  (cap_en),
    .cap_rise(cap_rise),
    .smp_stb (smp_stb),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_count(wr_count)
  );

  bank_seq_banks #(.DW(DATA_W), .AW(AW), .NB(NUM_BANKS)) u_banks (
    .clk    (clk),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(smp_data),
    .rd_en  (issue),
    .rd_addr(rd_addr),
    .rd_q   (bank_q)
  );

  bank_seq_reader #(.AW(AW), .SW(SW)) u_reader (
    .clk    (clk),
    .rst    (rst),
    .cap_en (cap_en),
    .rd_rise(rd_rise),
    .issue  (issue),
    .rd_addr(rd_addr),
    .slot   (slot),
    .done   (rd_done)
  );

  // Valid and slot follow the bank read by one cycle to stay aligned with its data.
  always_ff @(posedge clk) begin
    if (rst) tag_q <= '0;
    else     tag_q <= '{vld: issue, slot: slot};
  end

  assign out_slot = tag_q.slot;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    if (s < NUM_BANKS) begin : g_data
      assign slot_word[s] = bank_q[s*DATA_W +: DATA_W];
    end else begin : g_pad
      assign slot_word[s] = '0;
    end
  end

  assign rd_valid = tag_q.vld;
  assign rd_data  = tag_q.vld ? slot_word[out_slot] : '0;
endmodule

// File: rtl/bank_seq_chk.sv
module bank_seq_chk #(
  parameter int DATA_W = 8,
  parameter int NB     = 6,
  parameter int AW     = 8,
  parameter int SW     = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              cap_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid,
  input logic              rd_done,
  input logic [SW-1:0]     out_slot,
  input logic [AW:0]       wr_count
);
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> rd_data == '0); // R8

  AST_PAD_SLOTS: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && int'(out_slot) >= NB) |-> rd_data == '0); // R6

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    rd_done |=> !rd_valid); // R7

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rd_done && !$fell(cap_en)) |=> rd_done); // R7

  AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(cap_en) |=> !rd_done); // R7

  AST_CAPTURE_MUTE: assert property (@(posedge clk) disable iff (rst)
    cap_en |=> !rd_valid); // R9

  AST_WRITE_LIMIT: assert property (@(posedge clk) disable iff (rst)
    !(wr_count[AW] && (|wr_count[AW-1:0]))); // R3
endmodule

bind bank_seq bank_seq_chk #(
  .DATA_W(DATA_W),
  .NB    (NUM_BANKS),
  .AW    (AW),
  .SW    (SW)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cap_en  (cap_en),
  .rd_data (rd_data),
  .rd_valid(rd_valid),
  .rd_done (rd_done),
  .out_slot(out_slot),
  .wr_count(wr_count)
);

// File: tb/test_bank_seq.sv
module test_bank_seq;
  localparam int DW    = 8;
  localparam int NB    = 6;
  localparam int DEPTH = 256;
  localparam int TOTAL = 2048;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cap_en = 1'b1;
  logic              smp_stb = 1'b0;
  logic [NB*DW-1:0]  smp_data = '0;
  logic [DW-1:0]     rd_data;
  logic              rd_valid;
  logic              rd_done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int mon_idx = 0;
  logic [DW-1:0] model [NB][DEPTH];

  always #5 clk = ~clk;

  bank_seq i_bank_seq (
    .clk(clk), .rst(rst), .cap_en(cap_en), .smp_stb(smp_stb),
    .smp_data(smp_data), .rd_data(rd_data), .rd_valid(rd_valid), .rd_done(rd_done)
  );

  function automatic logic [DW-1:0] exp_word(int i);
    int s = i / DEPTH;
    if (s >= NB) return '0;
    return model[s][i % DEPTH];
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Output monitor: stream order and contents (R5, R6), idle zero (R8).
  always @(negedge clk) begin
    if (!rst) begin
      if (rd_valid) begin
        if (mon_idx < TOTAL)
          check(rd_data === exp_word(mon_idx), (mon_idx / DEPTH >= NB) ? "R6 pad word" : "R5 stream word",
                rd_data, exp_word(mon_idx));
        else
          check(1'b0, "R7 word beyond 2048", mon_idx, TOTAL);
        mon_idx++;
      end else if (rd_data !== '0) begin
        check(1'b0, "R8 data while not valid", rd_data, 0);
      end
    end
  end

  // Capture phase with n strobes at random spacing (R2, R3).
  task automatic capture(int n);
    int written = 0;
    int sent = 0;
    @(negedge clk);
    cap_en = 1'b1;
    while (sent < n) begin
      @(negedge clk);
      smp_stb  = ($urandom % 3) != 0;
      smp_data = {$urandom, $urandom};
      if (smp_stb) begin
        if (written < DEPTH) begin
          for (int b = 0; b < NB; b++) model[b][written] = smp_data[b*DW +: DW];
          written++;
        end
        sent++;
      end
    end
    @(negedge clk);
    smp_stb = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // Full readout phase followed by a long idle tail with stray strobes (R4, R7).
  task automatic readout_full();
    @(negedge clk);
    cap_en  = 1'b0;
    mon_idx = 0;
    repeat (2048) @(negedge clk);
    check(rd_done == 1'b0, "R7 done early", rd_done, 0);
    @(negedge clk);
    check(rd_valid && rd_done, "R7 done with last word", {rd_valid, rd_done}, 3);
    @(negedge clk);
    check(!rd_valid && rd_done, "R7 quiet after last word", {rd_valid, rd_done}, 1);
    repeat (300) begin
      @(negedge clk);
      smp_stb  = $urandom % 2;
      smp_data = {$urandom, $urandom};
    end
    @(negedge clk);
    smp_stb = 1'b0;
    check(mon_idx == TOTAL, "R7 word count", mon_idx, TOTAL);
    check(rd_done == 1'b1, "R7 done holds", rd_done, 1);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(rd_valid == 0 && rd_done == 0 && rd_data == 0, "R1 reset outputs",
          {rd_valid, rd_done, rd_data}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(rd_valid == 0 && rd_done == 0 && rd_data == 0, "R1 after reset",
          {rd_valid, rd_done, rd_data}, 0);

    // R2, R3: overfill the banks, then play everything back.
    capture(300);
    readout_full();

    // R2: short capture restarts at address 0, older words kept.
    capture(100);
    readout_full();

    // R4: capture phase with no strobes; the strobes of the idle tail must not have landed.
    capture(0);
    readout_full();

    // R9: abort a readout midway, then restart from word 0.
    capture(256);
    @(negedge clk);
    cap_en  = 1'b0;
    mon_idx = 0;
    repeat (600) @(negedge clk);
    cap_en = 1'b1;
    @(negedge clk);
    check(rd_valid == 0, "R9 valid drops on capture", rd_valid, 0);
    check(rd_done == 0, "R9 no done on abort", rd_done, 0);
    check(mon_idx > 0 && mon_idx < TOTAL, "R9 partial stream", mon_idx, 598);
    repeat (20) @(negedge clk);
    check(mon_idx < TOTAL && rd_valid == 0, "R9 stays stopped", mon_idx, 598);
    readout_full();

    // R1: reset in the middle of a readout.
    capture(256);
    @(negedge clk);
    cap_en  = 1'b0;
    mon_idx = 0;
    repeat (100) @(negedge clk);
    rst    = 1'b1;
    cap_en = 1'b1;
    @(negedge clk);
    check(rd_valid == 0 && rd_done == 0 && rd_data == 0, "R1 reset mid readout",
          {rd_valid, rd_done, rd_data}, 0);
    @(negedge clk);
    rst = 1'b0;
    capture(256);
    readout_full();

    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end
endmodule